// File: doc/BRIEF.md
# AT Command Numeric Token Parser

This block sits behind a UART receiver and turns a byte stream of text commands into a parsed token set. A command is the two capital letters `A` `T`, an optional command name of up to `NAME_MAX` printable characters, and an optional tail. The tail is either a query mark, or `=` followed by comma-separated parameters. A command ends at the first whitespace byte. Numeric parameters may be written in four radixes, told apart by their prefix. They may also be the literal `-1`. Each one is converted to a `NUM_W`-bit value. When the command name is `$SF`, the text after `=` is a raw hexadecimal payload of byte pairs. Optional numeric parameters may follow the payload after a comma.

For every terminated command, the block pulses exactly one of two strobes for one cycle. `cmd_ok` means the token fields are valid and the host may answer "OK". `cmd_err` means the text was malformed. After a syntax error, everything up to the next whitespace is swallowed, and the error is reported once, at that whitespace.

The controller has these states:
- `ST_IDLE`: between commands.
- `ST_GOT_A`: an `A` has been seen.
- `ST_NAME`: collecting the command name.
- `ST_QEND`: after a query mark, waiting for whitespace.
- `ST_NSTART`: waiting for the first character of a parameter.
- `ST_ZERO`: a leading zero has been seen.
- `ST_HPRE`: after `0x`, waiting for the first hex digit.
- `ST_BPRE`: after `0b`, waiting for the first binary digit.
- `ST_DIGS`: accumulating digits.
- `ST_NEG`: after `-`.
- `ST_NEG1`: after `-1`.
- `ST_PAY`: collecting payload nibbles.
- `ST_SKIP`: discarding input after an error.

The transitions are:
- IDLE→GOT_A on `A`.
- GOT_A→NAME on `T`.
- NAME→QEND on `?`.
- NAME→PAY on `=` when the name is `$SF`.
- NAME→NSTART on `=` for any other name.
- NSTART→ZERO on `0`.
- NSTART→DIGS on a digit 1–9.
- NSTART→NEG on `-`.
- NSTART→QEND on `?`.
- ZERO→HPRE on `x`.
- ZERO→BPRE on `b`.
- ZERO→DIGS on an octal digit.
- HPRE→DIGS and BPRE→DIGS on a valid digit.
- NEG→NEG1 on `1`.
- DIGS, ZERO or NEG1 →NSTART on a comma.
- PAY→NSTART on a comma.
- Any state →IDLE on whitespace that completes or rejects a command.
- Any state →SKIP on a non-whitespace syntax error.
- SKIP→IDLE on whitespace.

Top module: `atcmd_lexer`

## Requirements
- R1: A command must begin with uppercase `A` (0x41) then uppercase `T` (0x54). Lowercase or any other first bytes lead to a single `cmd_err` when the fragment is terminated.
- R2: Whitespace is 0x20 and 0x09–0x0D. Whitespace ends a command, and the strobe appears in the clock cycle after the terminating byte is accepted. Whitespace received between commands produces no strobe.
- R3: After a syntax error, no strobe is produced until the next whitespace, which produces exactly one `cmd_err`. The next command is then parsed normally.
- R4: A parameter with prefix `0x` is hexadecimal and one with prefix `0b` is binary. A `0` followed by more digits is octal. A lone `0`, or a number whose first digit is 1–9, is decimal.
- R5: Hex digits A–F are accepted in either case, both in `0x` numbers and in payloads. The prefix letters `x` and `b` are lowercase only.
- R6: The literal `-1` gives an all-ones value and sets that parameter's bit in `prm_neg`. Any other text after `-` is an error.
- R7: A number whose value exceeds `NUM_W` bits gives `cmd_err`.
- R8: A digit not valid for the detected radix gives `cmd_err`, and so does a prefix with no digit after it.
- R9: Parameters are separated by commas, and parameter i is held in `prm_vals[32*i +: 32]`. Up to `MAX_PRM` parameters are accepted and counted in `prm_count`. One more parameter, or an empty parameter, gives `cmd_err`.
- R10: For name `$SF`, the text after `=` is a payload of hex digit pairs. The first byte is placed in `pay_data[7:0]`. Each byte's first digit is its high nibble. The payload holds 1 to `MAX_PAY` bytes, and `pay_valid` marks it. An odd digit count, an empty payload or an oversized payload gives `cmd_err`.
- R11: A `?` directly after the name, or directly after `=`, sets `cmd_query`. The `?` must then be followed by whitespace. `cmd_assign` shows that `=` was seen.
- R12: Both strobes are low out of reset, are never high together, and each lasts one cycle.
- R13: The name characters after `AT` are placed in `cmd_name`, with the last character in bits [7:0], and their count goes to `cmd_name_len`. A name longer than `NAME_MAX` gives `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| cmd_ok | output | 1 | One-cycle strobe: a well-formed command ended |
| cmd_err | output | 1 | One-cycle strobe: a malformed command ended |
| cmd_name | output | 8*NAME_MAX | Name characters, last in the low byte |
| cmd_name_len | output | clog2(NAME_MAX+1) | Number of name characters |
| cmd_query | output | 1 | The command used a query mark |
| cmd_assign | output | 1 | The command used `=` |
| prm_count | output | clog2(MAX_PRM+1) | Number of numeric parameters |
| prm_vals | output | MAX_PRM*NUM_W | Parameter values, parameter 0 lowest |
| prm_neg | output | MAX_PRM | Parameter was the literal -1 |
| pay_valid | output | 1 | The command carried a hex payload |
| pay_len | output | clog2(MAX_PAY+1) | Payload byte count |
| pay_data | output | 8*MAX_PAY | Payload bytes, first byte lowest |

## Verification
A wrong state in this block becomes visible at the terminating whitespace of the command being parsed. That whitespace either produces the wrong strobe, a strobe with the wrong field values, or a second strobe one command later if the error recovery has lost track. A corrupted accumulator or radix selection shows up at once in `prm_vals` on that command's `cmd_ok`. The boundary vectors are 2^32−1 against 2^32, nine hex digits, 12 against 13 payload bytes, and four against five parameters. These are placed so that an off-by-one in any limit flips a strobe on that same command.

// File: rtl/atcmd_pkg.sv
package atcmd_pkg;

    typedef enum logic [1:0] {
        RAD_DEC,
        RAD_OCT,
        RAD_HEX,
        RAD_BIN
    } radix_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GOT_A,
        ST_NAME,
        ST_QEND,
        ST_NSTART,
        ST_ZERO,
        ST_HPRE,
        ST_BPRE,
        ST_DIGS,
        ST_NEG,
        ST_NEG1,
        ST_PAY,
        ST_SKIP
    } lex_state_e;

    localparam logic [7:0] CH_A     = 8'h41;
    localparam logic [7:0] CH_T     = 8'h54;
    localparam logic [7:0] CH_EQ    = 8'h3D;
    localparam logic [7:0] CH_QMARK = 8'h3F;
    localparam logic [7:0] CH_COMMA = 8'h2C;
    localparam logic [7:0] CH_MINUS = 8'h2D;
    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_ONE   = 8'h31;
    localparam logic [7:0] CH_LX    = 8'h78;
    localparam logic [7:0] CH_LB    = 8'h62;

    // command name that switches the tail to a raw hex payload: "$SF"
    localparam logic [23:0] FRAME_TAG     = 24'h245346;
    localparam int          FRAME_TAG_LEN = 3;

endpackage

// File: rtl/atcmd_charclass.sv
module atcmd_charclass
    import atcmd_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_ws,
    output logic       is_dec,
    output logic       is_oct,
    output logic       is_bin,
    output logic       is_hex,
    output logic       is_name,
    output logic [3:0] nib
);

    always_comb begin
        is_ws  = (ch == 8'h20) || ((ch >= 8'h09) && (ch <= 8'h0D));
        is_dec = (ch >= 8'h30) && (ch <= 8'h39);
        is_oct = (ch >= 8'h30) && (ch <= 8'h37);
        is_bin = (ch == CH_ZERO) || (ch == CH_ONE);
        is_hex = 1'b0;
        nib    = 4'd0;
        if (is_dec) begin
            is_hex = 1'b1;
            nib    = ch[3:0];
        end else if (((ch >= 8'h41) && (ch <= 8'h46)) || ((ch >= 8'h61) && (ch <= 8'h66))) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
        is_name = (ch >= 8'h21) && (ch <= 8'h7E) &&
                  (ch != CH_EQ) && (ch != CH_QMARK) && (ch != CH_COMMA);
    end

endmodule

// File: rtl/atcmd_numacc.sv
module atcmd_numacc
    import atcmd_pkg::*;
#(
    parameter int NUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  radix_e           radix,
    input  logic [3:0]       digit,
    output logic [NUM_W-1:0] value,
    output logic             would_ovf
);

    localparam int XW = NUM_W + 4;

    logic [NUM_W-1:0] base;
    logic [XW-1:0]    scaled;
    logic [XW-1:0]    wide;

    always_comb begin
        base = clr ? '0 : value;
        unique case (radix)
            RAD_BIN: scaled = {4'b0, base} << 1;
            RAD_OCT: scaled = {4'b0, base} << 3;
            RAD_HEX: scaled = {4'b0, base} << 4;
            default: scaled = ({4'b0, base} << 3) + ({4'b0, base} << 1);
        endcase
        wide      = scaled + {{(XW-4){1'b0}}, digit};
        would_ovf = |wide[XW-1:NUM_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (en) begin
            value <= wide[NUM_W-1:0];
        end else if (clr) begin
            value <= '0;
        end
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((radix != RAD_BIN || digit <= 4'd1) &&
                (radix != RAD_OCT || digit <= 4'd7) &&
                (radix != RAD_DEC || digit <= 4'd9))); // R8

endmodule

// File: rtl/atcmd_paybuf.sv
module atcmd_paybuf #(
    parameter int MAX_PAY = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           en,
    input  logic [3:0]                     nib,
    output logic [8*MAX_PAY-1:0]           bytes_o,
    output logic [$clog2(MAX_PAY+1)-1:0]   count,
    output logic                           half,
    output logic                           full
);

    localparam int CW = $clog2(MAX_PAY+1);
    localparam logic [CW-1:0] LIM = CW'(MAX_PAY);

    logic [3:0] hi_nib;
    logic [7:0] mem [MAX_PAY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_nib <= '0;
            half   <= 1'b0;
            count  <= '0;
        end else if (clr) begin
            hi_nib <= '0;
            half   <= 1'b0;
            count  <= '0;
        end else if (en) begin
            if (!half) begin
                hi_nib <= nib;
                half   <= 1'b1;
            end else begin
                half  <= 1'b0;
                count <= count + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < MAX_PAY; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (clr) begin
                mem[i] <= '0;
            end else if (en && half && (count == CW'(i))) begin
                mem[i] <= {hi_nib, nib};
            end
        end
        assign bytes_o[8*i +: 8] = mem[i];
    end

    assign full = (count == LIM);

    AST_PAY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !half) |-> !full); // R10

endmodule

// File: rtl/atcmd_lexer.sv
module atcmd_lexer
    import atcmd_pkg::*;
#(
    parameter int NUM_W    = 32,
    parameter int MAX_PRM  = 4,
    parameter int MAX_PAY  = 12,
    parameter int NAME_MAX = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [7:0]                      in_byte,
    output logic                            cmd_ok,
    output logic                            cmd_err,
    output logic [8*NAME_MAX-1:0]           cmd_name,
    output logic [$clog2(NAME_MAX+1)-1:0]   cmd_name_len,
    output logic                            cmd_query,
    output logic                            cmd_assign,
    output logic [$clog2(MAX_PRM+1)-1:0]    prm_count,
    output logic [MAX_PRM*NUM_W-1:0]        prm_vals,
    output logic [MAX_PRM-1:0]              prm_neg,
    output logic                            pay_valid,
    output logic [$clog2(MAX_PAY+1)-1:0]    pay_len,
    output logic [8*MAX_PAY-1:0]            pay_data
);

    localparam int NW  = 8 * NAME_MAX;
    localparam int NLW = $clog2(NAME_MAX+1);
    localparam int PCW = $clog2(MAX_PRM+1);
    localparam int PLW = $clog2(MAX_PAY+1);
    localparam logic [NLW-1:0] NAME_LIM  = NLW'(NAME_MAX);
    localparam logic [PCW-1:0] PRM_LIM   = PCW'(MAX_PRM);
    localparam logic [PLW-1:0] PAY_LIM   = PLW'(MAX_PAY);
    localparam logic [NW-1:0]  FRAME_ID  = NW'(FRAME_TAG);
    localparam logic [NLW-1:0] FRAME_LEN = NLW'(FRAME_TAG_LEN);

    // character classes
    logic       c_ws, c_dec, c_oct, c_bin, c_hex, c_name;
    logic [3:0] c_nib;

    atcmd_charclass u_class (
        .ch      (in_byte),
        .is_ws   (c_ws),
        .is_dec  (c_dec),
        .is_oct  (c_oct),
        .is_bin  (c_bin),
        .is_hex  (c_hex),
        .is_name (c_name),
        .nib     (c_nib)
    );

    // state and token registers
    lex_state_e        st_q, st_d;
    radix_e            radix_q, radix_d, acc_rad;
    logic [NW-1:0]     name_q;
    logic [NLW-1:0]    name_len_q;
    logic              query_q, assign_q, frame_q;
    logic [PCW-1:0]    prm_cnt_q;
    logic [NUM_W-1:0]  prm_arr [MAX_PRM];
    logic [MAX_PRM-1:0] prm_neg_q;

    // controls from the state machine
    logic clr_all, name_push, radix_set, acc_clr, acc_en, pay_en;
    logic set_query, set_assign, set_frame;
    logic want_commit, want_neg, commit, commit_neg;
    logic fail, fire_ok, fire_err;
    logic dig_ok;

    // datapath helpers
    logic [NUM_W-1:0] acc_val;
    logic             acc_ovf;
    logic [PLW-1:0]   pay_cnt;
    logic             pay_half, pay_full;

    atcmd_numacc #(.NUM_W(NUM_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (acc_clr),
        .en        (acc_en),
        .radix     (acc_rad),
        .digit     (c_nib),
        .value     (acc_val),
        .would_ovf (acc_ovf)
    );

    atcmd_paybuf #(.MAX_PAY(MAX_PAY)) u_pay (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_all),
        .en      (pay_en),
        .nib     (c_nib),
        .bytes_o (pay_data),
        .count   (pay_cnt),
        .half    (pay_half),
        .full    (pay_full)
    );

    always_comb begin
        unique case (radix_q)
            RAD_BIN: dig_ok = c_bin;
            RAD_OCT: dig_ok = c_oct;
            RAD_HEX: dig_ok = c_hex;
            default: dig_ok = c_dec;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and control outputs
    always_comb begin
        st_d        = st_q;
        clr_all     = 1'b0;
        name_push   = 1'b0;
        radix_set   = 1'b0;
        radix_d     = radix_q;
        acc_clr     = 1'b0;
        acc_en      = 1'b0;
        acc_rad     = radix_q;
        pay_en      = 1'b0;
        set_query   = 1'b0;
        set_assign  = 1'b0;
        set_frame   = 1'b0;
        want_commit = 1'b0;
        want_neg    = 1'b0;
        commit      = 1'b0;
        commit_neg  = 1'b0;
        fail        = 1'b0;
        fire_ok     = 1'b0;
        fire_err    = 1'b0;
        if (in_valid) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (in_byte == CH_A) begin
                        st_d    = ST_GOT_A;
                        clr_all = 1'b1;
                    end else if (!c_ws) begin
                        st_d = ST_SKIP;
                    end
                end
                ST_GOT_A: begin
                    if (in_byte == CH_T) st_d = ST_NAME;
                    else                 fail = 1'b1;
                end
                ST_NAME: begin
                    if (c_ws) begin
                        fire_ok = 1'b1;
                        st_d    = ST_IDLE;
                    end else if (in_byte == CH_QMARK) begin
                        set_query = 1'b1;
                        st_d      = ST_QEND;
                    end else if (in_byte == CH_EQ) begin
                        set_assign = 1'b1;
                        if ((name_q == FRAME_ID) && (name_len_q == FRAME_LEN)) begin
                            set_frame = 1'b1;
                            st_d      = ST_PAY;
                        end else begin
                            st_d = ST_NSTART;
                        end
                    end else if (c_name && (name_len_q != NAME_LIM)) begin
                        name_push = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_QEND: begin
                    if (c_ws) begin
                        fire_ok = 1'b1;
                        st_d    = ST_IDLE;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_NSTART: begin
                    acc_clr = 1'b1;
                    acc_rad = RAD_DEC;
                    if (in_byte == CH_ZERO) begin
                        acc_en = 1'b1;
                        st_d   = ST_ZERO;
                    end else if (c_dec) begin
                        acc_en    = 1'b1;
                        radix_set = 1'b1;
                        radix_d   = RAD_DEC;
                        st_d      = ST_DIGS;
                    end else if (in_byte == CH_MINUS) begin
                        st_d = ST_NEG;
                    end else if ((in_byte == CH_QMARK) && (prm_cnt_q == '0) && !frame_q) begin
                        set_query = 1'b1;
                        st_d      = ST_QEND;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_ZERO: begin
                    acc_rad = RAD_OCT;
                    if (in_byte == CH_LX) begin
                        radix_set = 1'b1;
                        radix_d   = RAD_HEX;
                        st_d      = ST_HPRE;
                    end else if (in_byte == CH_LB) begin
                        radix_set = 1'b1;
                        radix_d   = RAD_BIN;
                        st_d      = ST_BPRE;
                    end else if (c_oct) begin
                        acc_en    = 1'b1;
                        radix_set = 1'b1;
                        radix_d   = RAD_OCT;
                        st_d      = ST_DIGS;
                    end else if (c_ws || (in_byte == CH_COMMA)) begin
                        want_commit = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_HPRE, ST_BPRE: begin
                    if (dig_ok) begin
                        acc_en = 1'b1;
                        st_d   = ST_DIGS;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_DIGS: begin
                    if (c_ws || (in_byte == CH_COMMA)) begin
                        want_commit = 1'b1;
                    end else if (dig_ok && !acc_ovf) begin
                        acc_en = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_NEG: begin
                    if (in_byte == CH_ONE) st_d = ST_NEG1;
                    else                   fail = 1'b1;
                end
                ST_NEG1: begin
                    if (c_ws || (in_byte == CH_COMMA)) begin
                        want_commit = 1'b1;
                        want_neg    = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_PAY: begin
                    if (c_hex) begin
                        if (pay_full) fail = 1'b1;
                        else          pay_en = 1'b1;
                    end else if (c_ws || (in_byte == CH_COMMA)) begin
                        if (pay_half || (pay_cnt == '0)) begin
                            fail = 1'b1;
                        end else if (c_ws) begin
                            fire_ok = 1'b1;
                            st_d    = ST_IDLE;
                        end else begin
                            st_d = ST_NSTART;
                        end
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (c_ws) begin
                        fire_err = 1'b1;
                        st_d     = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase

            if (want_commit) begin
                if (prm_cnt_q == PRM_LIM) begin
                    fail = 1'b1;
                end else begin
                    commit     = 1'b1;
                    commit_neg = want_neg;
                    if (c_ws) begin
                        fire_ok = 1'b1;
                        st_d    = ST_IDLE;
                    end else begin
                        st_d = ST_NSTART;
                    end
                end
            end

            if (fail) begin
                if (c_ws) begin
                    fire_err = 1'b1;
                    st_d     = ST_IDLE;
                end else begin
                    st_d = ST_SKIP;
                end
            end
        end
    end

    // token registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_ok     <= 1'b0;
            cmd_err    <= 1'b0;
            radix_q    <= RAD_DEC;
            name_q     <= '0;
            name_len_q <= '0;
            query_q    <= 1'b0;
            assign_q   <= 1'b0;
            frame_q    <= 1'b0;
            prm_cnt_q  <= '0;
            prm_neg_q  <= '0;
            for (int i = 0; i < MAX_PRM; i++) prm_arr[i] <= '0;
        end else begin
            cmd_ok  <= fire_ok;
            cmd_err <= fire_err;
            if (radix_set) radix_q <= radix_d;
            if (clr_all) begin
                name_q     <= '0;
                name_len_q <= '0;
                query_q    <= 1'b0;
                assign_q   <= 1'b0;
                frame_q    <= 1'b0;
                prm_cnt_q  <= '0;
                prm_neg_q  <= '0;
                for (int i = 0; i < MAX_PRM; i++) prm_arr[i] <= '0;
            end else begin
                if (name_push) begin
                    name_q     <= {name_q[NW-9:0], in_byte};
                    name_len_q <= name_len_q + 1'b1;
                end
                if (set_query)  query_q  <= 1'b1;
                if (set_assign) assign_q <= 1'b1;
                if (set_frame)  frame_q  <= 1'b1;
                if (commit) begin
                    for (int i = 0; i < MAX_PRM; i++) begin
                        if (prm_cnt_q == PCW'(i)) begin
                            prm_arr[i]   <= commit_neg ? '1 : acc_val;
                            prm_neg_q[i] <= commit_neg;
                        end
                    end
                    prm_cnt_q <= prm_cnt_q + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < MAX_PRM; g++) begin : g_prm
        assign prm_vals[g*NUM_W +: NUM_W] = prm_arr[g];
    end

    assign cmd_name     = name_q;
    assign cmd_name_len = name_len_q;
    assign cmd_query    = query_q;
    assign cmd_assign   = assign_q;
    assign prm_count    = prm_cnt_q;
    assign prm_neg      = prm_neg_q;
    assign pay_valid    = frame_q;
    assign pay_len      = pay_cnt;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_err)); // R12
    AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> !cmd_ok); // R12
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err); // R12
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok || cmd_err) |-> $past(in_valid)); // R2
    AST_PRM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |-> (prm_count <= PRM_LIM)); // R9
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && pay_valid) |-> ((pay_len != '0) && (pay_len <= PAY_LIM))); // R10
    AST_NEG_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && prm_neg[0]) |-> (&prm_vals[NUM_W-1:0])); // R6

endmodule

// File: tb/atcmd_lexer_bench.sv
module atcmd_lexer_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = 8'h00;
    logic         cmd_ok, cmd_err, cmd_query, cmd_assign, pay_valid;
    logic [31:0]  cmd_name;
    logic [2:0]   cmd_name_len;
    logic [2:0]   prm_count;
    logic [127:0] prm_vals;
    logic [3:0]   prm_neg;
    logic [3:0]   pay_len;
    logic [95:0]  pay_data;

    always #10 clk = ~clk;

    atcmd_lexer u_atcmd_lexer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .cmd_ok       (cmd_ok),
        .cmd_err      (cmd_err),
        .cmd_name     (cmd_name),
        .cmd_name_len (cmd_name_len),
        .cmd_query    (cmd_query),
        .cmd_assign   (cmd_assign),
        .prm_count    (prm_count),
        .prm_vals     (prm_vals),
        .prm_neg      (prm_neg),
        .pay_valid    (pay_valid),
        .pay_len      (pay_len),
        .pay_data     (pay_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_ok     = 0;
    int n_err    = 0;

    logic [31:0]  s_name;
    logic [2:0]   s_nlen, s_cnt;
    logic         s_query, s_assign, s_payv;
    logic [127:0] s_vals;
    logic [3:0]   s_neg, s_plen;
    logic [95:0]  s_pdata;

    localparam int NV = 21;
    localparam logic [8*24-1:0] V_TXT [NV] = '{
        "AT ",                  "AT$SB=1\n",          "AT$TR=0x1F ",
        "ATS300=017 ",          "AT$X=0b101,42 ",     "AT$X=0xaBcD\t",
        "AT$X=4294967295\013",  "AT$X=4294967296 ",   "AT$X=0x100000000 ",
        "AT$X=08 ",             "AT$X=0b102 ",        "AT$X=0x ",
        "at ",                  "AX ",                "AT$X=1,2,3,4 ",
        "AT$X=1,2,3,4,5 ",      "AT$X=1, ",           "AT$TR? ",
        "AT$SF=abc ",           "AT$X=0 ",            "AT$CB=-1,1 "
    };
    localparam bit V_OK [NV] = '{1,1,1, 1,1,1, 1,0,0, 0,0,0, 0,0,1, 0,0,1, 0,1,1};
    localparam int V_CNT [NV] = '{0,1,1, 1,2,1, 1,0,0, 0,0,0, 0,0,4, 0,0,0, 0,1,2};
    localparam logic [31:0] V_P0 [NV] = '{
        32'd0, 32'd1, 32'd31, 32'd15, 32'd5, 32'hABCD, 32'hFFFFFFFF, 32'd0, 32'd0,
        32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'd0, 32'd0, 32'd0, 32'd0,
        32'd0, 32'hFFFFFFFF
    };
    localparam logic [8*3-1:0] V_REQ [NV] = '{
        "R1", "R2", "R4", "R4", "R4", "R5", "R7", "R7", "R7", "R8", "R8",
        "R8", "R1", "R1", "R9", "R9", "R9", "R11", "R10", "R4", "R6"
    };

    task automatic chk(input bit cond, input logic [8*3-1:0] req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        if (cmd_err) n_err++;
        if (cmd_ok) begin
            n_ok++;
            s_name = cmd_name;  s_nlen = cmd_name_len; s_cnt = prm_count;
            s_query = cmd_query; s_assign = cmd_assign; s_vals = prm_vals;
            s_neg = prm_neg; s_payv = pay_valid; s_plen = pay_len; s_pdata = pay_data;
        end
    endtask

    task automatic send_txt(input logic [8*24-1:0] t);
        for (int k = 23; k >= 0; k--) begin
            if (t[8*k +: 8] != 8'h00) send_byte(t[8*k +: 8]);
        end
    endtask

    task automatic clr_cnt();
        n_ok = 0;
        n_err = 0;
    endtask

    function automatic logic [7:0] hexc(input int v);
        return (v < 10) ? 8'(8'h30 + v) : 8'(8'h41 + v - 10);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // reset state: R12
        chk(!cmd_ok && !cmd_err, "R12", "strobes in reset", {cmd_ok, cmd_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_ok && !cmd_err && prm_count == 0 && pay_len == 0, "R12", "after reset",
            {cmd_ok, cmd_err, prm_count, pay_len}, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            clr_cnt();
            send_txt(V_TXT[v]);
            if (V_OK[v]) begin
                chk(n_ok == 1 && n_err == 0, V_REQ[v], $sformatf("vec %0d ok strobe", v),
                    {n_ok[7:0], n_err[7:0]}, 16'h0100);
                chk(s_cnt == 3'(V_CNT[v]), V_REQ[v], $sformatf("vec %0d count", v),
                    s_cnt, V_CNT[v]);
                chk(s_vals[31:0] == V_P0[v], V_REQ[v], $sformatf("vec %0d p0", v),
                    s_vals[31:0], V_P0[v]);
            end else begin
                chk(n_ok == 0 && n_err == 1, V_REQ[v], $sformatf("vec %0d err strobe", v),
                    {n_ok[7:0], n_err[7:0]}, 16'h0001);
            end
        end

        // R2: idle whitespace gives no strobe
        clr_cnt();
        send_txt("  \t\n ");
        chk(n_ok == 0 && n_err == 0, "R2", "idle whitespace", {n_ok[7:0], n_err[7:0]}, 0);

        // R10 and R5: payload bytes, first byte lowest, mixed case
        clr_cnt();
        send_txt("AT$SF=aaBB1234 ");
        chk(n_ok == 1 && s_payv && s_plen == 4, "R10", "payload len", {n_ok[7:0], s_payv, s_plen}, {8'd1, 1'b1, 4'd4});
        chk(s_pdata[31:0] == 32'h3412BBAA, "R5", "payload bytes", s_pdata[31:0], 32'h3412BBAA);
        chk(s_name == 32'h00245346 && s_nlen == 3, "R13", "frame name", {s_name, s_nlen}, {32'h00245346, 3'd3});

        // R10: payload with flag parameter
        clr_cnt();
        send_txt("AT$SF=0011,1 ");
        chk(n_ok == 1 && s_cnt == 1 && s_vals[31:0] == 1 && s_plen == 2, "R10", "payload + flag",
            {s_cnt, s_vals[31:0], s_plen}, {3'd1, 32'd1, 4'd2});

        // R10: exactly 12 bytes accepted
        clr_cnt();
        send_txt("AT$SF=");
        for (int i = 1; i <= 12; i++) begin
            send_byte(hexc(i / 16));
            send_byte(hexc(i % 16));
        end
        send_byte(8'h20);
        chk(n_ok == 1 && s_plen == 12 && s_pdata[95:88] == 8'h0C && s_pdata[7:0] == 8'h01, "R10",
            "12 bytes", {n_ok[7:0], s_plen, s_pdata[95:88], s_pdata[7:0]}, {8'd1, 4'd12, 8'h0C, 8'h01});

        // R10: 13 bytes rejected
        clr_cnt();
        send_txt("AT$SF=");
        for (int i = 0; i < 26; i++) send_byte(hexc(i % 10));
        send_byte(8'h20);
        chk(n_ok == 0 && n_err == 1, "R10", "13 bytes", {n_ok[7:0], n_err[7:0]}, 16'h0001);

        // R10: empty payload rejected
        clr_cnt();
        send_txt("AT$SF= ");
        chk(n_ok == 0 && n_err == 1, "R10", "empty payload", {n_ok[7:0], n_err[7:0]}, 16'h0001);

        // R3: recovery discards until whitespace, single error, then normal parse
        clr_cnt();
        send_txt("AT$X=1q,5");
        chk(n_ok == 0 && n_err == 0, "R3", "no strobe while skipping", {n_ok[7:0], n_err[7:0]}, 0);
        send_byte(8'h20);
        chk(n_ok == 0 && n_err == 1, "R3", "one error at whitespace", {n_ok[7:0], n_err[7:0]}, 16'h0001);
        clr_cnt();
        send_txt("AT$SB=7 ");
        chk(n_ok == 1 && n_err == 0 && s_vals[31:0] == 7, "R3", "parse after recovery",
            {n_ok[7:0], n_err[7:0], s_vals[31:0]}, {8'd1, 8'd0, 32'd7});

        // R13: four character name captured, five rejected
        clr_cnt();
        send_txt("ATS300=1 ");
        chk(n_ok == 1 && s_name == 32'h53333030 && s_nlen == 4, "R13", "name capture",
            {s_name, s_nlen}, {32'h53333030, 3'd4});
        clr_cnt();
        send_txt("AT$ABCD=1 ");
        chk(n_ok == 0 && n_err == 1, "R13", "name too long", {n_ok[7:0], n_err[7:0]}, 16'h0001);

        // R6: neg mask and bad negative
        clr_cnt();
        send_txt("AT$CB=5,-1 ");
        chk(n_ok == 1 && s_neg == 4'b0010 && s_vals[63:32] == 32'hFFFFFFFF, "R6", "neg mask",
            {s_neg, s_vals[63:32]}, {4'b0010, 32'hFFFFFFFF});
        clr_cnt();
        send_txt("AT$CB=-2 ");
        chk(n_ok == 0 && n_err == 1, "R6", "minus two", {n_ok[7:0], n_err[7:0]}, 16'h0001);

        // R11: range query and misplaced query
        clr_cnt();
        send_txt("AT$TR=? ");
        chk(n_ok == 1 && s_query && s_assign && s_cnt == 0, "R11", "range query",
            {s_query, s_assign, s_cnt}, {1'b1, 1'b1, 3'd0});
        clr_cnt();
        send_txt("AT$TR=1? ");
        chk(n_ok == 0 && n_err == 1, "R11", "late query", {n_ok[7:0], n_err[7:0]}, 16'h0001);

        // R9: fourth parameter position
        clr_cnt();
        send_txt("AT$X=9,0b11,010,0xfe ");
        chk(n_ok == 1 && s_vals == {32'hFE, 32'd8, 32'd3, 32'd9} && s_cnt == 4, "R9", "four params",
            s_vals, {32'hFE, 32'd8, 32'd3, 32'd9});

        finish_run();
    end

endmodule